// File: doc/BRIEF.md
# Auto-Increment Word Programmer for Serial Flash

This block is an SPI master that moves a stream of bytes into a serial flash device using the flash's auto-address-increment word program mode. The host gives a start address, a byte count and a `start` pulse, then feeds the bytes on a valid/ready stream. The block waits until the flash reports idle, sets the write latch, and sends one long frame that carries the opcode, the address and the first two bytes. Every later pair of bytes goes out in a short frame with no address, because the flash advances its own address. The block polls the flash status between these short frames, and a write-disable frame closes the sequence.

The SPI link runs in mode 0: the clock idles low, the flash samples on the rising edge, and bytes go out most significant bit first. Each clock phase lasts `CLK_DIV` system cycles. Chip select stays high for `GAP_CYC` cycles between frames. When the count is odd, the block pads the last word with an erased-state byte. A zero count finishes at once.

Top module: `aai_word_writer`

## Requirements
- R1: After `start` with a non-zero count, the first frames are status polls and then a one-byte write-enable frame (0x06). A status poll is a two-byte frame: opcode 0x05 followed by a 0x00 dummy byte. Bit 0 of the byte returned during the dummy byte is the flash busy flag. The poll repeats, each time in a fresh frame, until that bit reads 0.
- R2: The first program frame has six bytes: 0xAD, then the three address bytes with the most significant first, then the first two stream bytes in arrival order.
- R3: Each later program frame is exactly 0xAD followed by the next two stream bytes, with no address. It is preceded by one or more status poll frames that follow the R1 repeat rule.
- R4: The block sends (count+1)/2 program frames, rounding down. When the count is odd, the final byte of the last frame is 0xFF. The stream gives up exactly `count` bytes, so the pad byte consumes nothing.
- R5: A one-byte frame 0x04 follows the last program frame directly, with no poll between them.
- R6: `done` is high for exactly one cycle, after the write-disable frame has ended. `busy` is high from the cycle after an accepted `start` through the `done` cycle, and low afterwards.
- R7: A zero count raises `done` in the cycle after `start`. It produces no chip-select activity and no `in_ready`.
- R8: Mode 0 framing: `spi_sclk` is low whenever `spi_cs_n` is high, `spi_mosi` holds steady while `spi_sclk` is high, and `spi_cs_n` stays high while the block is idle.
- R9: A `start` pulse while `busy` is high is ignored. The frames of the running sequence are unchanged, and there is no extra `done`.
- R10: When a data byte is due and `in_valid` is low, the block pauses the SPI clock and keeps chip select low. `in_ready` is only raised inside a frame. No stream byte is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming sequence (taken only when idle) |
| start_addr | input | 8*ADDR_BYTES | First flash byte address |
| byte_count | input | CNT_W | Number of bytes to program |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte available |
| in_ready | output | 1 | Block takes the stream byte this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The assertions take several properties of the inputs for granted:
- `start_addr` and `byte_count` are stable in the cycle `start` is sampled.
- The stream holds at least `byte_count` bytes.
- The flash follows mode 0 and drives the busy bit before the sampling edge of the dummy byte.

The bench meets these assumptions as follows:
- It drives every input on the falling system edge.
- It preloads a byte queue of exactly the requested length.
- It uses a slave model that loads its status byte on the rising edge that ends the opcode and shifts only on later falling edges.

The slave model reports busy for a chosen number of polls after each non-poll frame. This exercises the repeat paths.

// File: rtl/aai_word_writer.sv
module aai_word_writer #(
  parameter int ADDR_BYTES = 3,
  parameter int CNT_W      = 16,
  parameter int CLK_DIV    = 2,
  parameter int GAP_CYC    = 2,
  parameter int BUSY_BIT   = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [8*ADDR_BYTES-1:0] start_addr,
  input  logic [CNT_W-1:0]        byte_count,
  input  logic [7:0]              in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic                    busy,
  output logic                    done,
  output logic                    spi_sclk,
  output logic                    spi_cs_n,
  output logic                    spi_mosi,
  input  logic                    spi_miso
);
  localparam int ADDR_W  = 8 * ADDR_BYTES;
  localparam int IDX_W   = $clog2(ADDR_BYTES + 4);
  localparam int CNT_MAX = (CLK_DIV > GAP_CYC) ? CLK_DIV : GAP_CYC;
  localparam int DIV_W   = $clog2(CNT_MAX + 1);
  localparam logic [7:0] OP_POLL = 8'h05, OP_WREN = 8'h06, OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WORD = 8'hAD, PAD = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_SHIFT, S_GAP, S_DONE} st_t;
  typedef enum logic [2:0] {F_POLL, F_WREN, F_FIRST, F_WORD, F_WRDI} fr_t;

  st_t               st;
  fr_t               ft;
  logic [IDX_W-1:0]  idx, flen;
  logic [2:0]        bitn;
  logic [DIV_W-1:0]  div;
  logic [7:0]        tx_sh, ctrl_byte;
  logic [ADDR_W-1:0] addr_sh;
  logic [CNT_W-1:0]  bytes_left, words_left;
  logic [CNT_W:0]    words_init;
  logic              sclk_q, poll_busy, wren_sent;
  logic              is_data, need_stream, load_ok, last_idx, half_tick;

  always_comb begin
    case (ft)
      F_POLL:  flen = IDX_W'(2);
      F_FIRST: flen = IDX_W'(ADDR_BYTES + 3);
      F_WORD:  flen = IDX_W'(3);
      default: flen = IDX_W'(1);
    endcase
    case (ft)
      F_POLL:  ctrl_byte = (idx == '0) ? OP_POLL : 8'h00;
      F_WREN:  ctrl_byte = OP_WREN;
      F_WRDI:  ctrl_byte = OP_WRDI;
      F_FIRST: ctrl_byte = (idx == '0) ? OP_WORD : addr_sh[ADDR_W-1 -: 8];
      default: ctrl_byte = OP_WORD;
    endcase
  end

  assign words_init  = ({1'b0, byte_count} + 1'b1) >> 1;
  assign is_data     = (ft == F_FIRST && idx > IDX_W'(ADDR_BYTES)) || (ft == F_WORD && idx != '0);
  assign need_stream = is_data && (bytes_left != '0);
  assign load_ok     = (st == S_LOAD) && (!need_stream || in_valid);
  assign in_ready    = (st == S_LOAD) && need_stream;
  assign last_idx    = (idx == flen - 1'b1);
  assign half_tick   = (div == DIV_W'(CLK_DIV - 1));
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_DONE);
  assign spi_cs_n    = !(st == S_LOAD || st == S_SHIFT);
  assign spi_sclk    = sclk_q;
  assign spi_mosi    = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ft <= F_POLL; idx <= '0; bitn <= '0; div <= '0;
      tx_sh <= '0; addr_sh <= '0; bytes_left <= '0; words_left <= '0;
      sclk_q <= 1'b0; poll_busy <= 1'b0; wren_sent <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (byte_count == '0) st <= S_DONE;
          else begin
            addr_sh    <= start_addr;
            bytes_left <= byte_count;
            words_left <= words_init[CNT_W-1:0];
            wren_sent  <= 1'b0;
            ft         <= F_POLL;
            idx        <= '0;
            st         <= S_LOAD;
          end
        end
        S_LOAD: if (load_ok) begin
          tx_sh <= need_stream ? in_data : (is_data ? PAD : ctrl_byte);
          if (need_stream) bytes_left <= bytes_left - 1'b1;
          if (ft == F_FIRST && idx != '0 && !is_data) addr_sh <= addr_sh << 8;
          div  <= '0;
          bitn <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: if (half_tick) begin
          div <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            if (ft == F_POLL && idx == IDX_W'(1) && bitn == 3'(7 - BUSY_BIT))
              poll_busy <= spi_miso;
          end else begin
            sclk_q <= 1'b0;
            tx_sh  <= tx_sh << 1;
            bitn   <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              if (last_idx) begin
                st <= S_GAP;
                if (ft == F_FIRST || ft == F_WORD) words_left <= words_left - 1'b1;
              end else begin
                idx <= idx + 1'b1;
                st  <= S_LOAD;
              end
            end
          end
        end else div <= div + 1'b1;
        S_GAP: if (div == DIV_W'(GAP_CYC - 1)) begin
          div <= '0;
          idx <= '0;
          st  <= S_LOAD;
          case (ft)
            F_POLL:  if (!poll_busy) ft <= wren_sent ? F_WORD : F_WREN;
            F_WREN:  begin wren_sent <= 1'b1; ft <= F_FIRST; end
            F_WRDI:  st <= S_DONE;
            default: ft <= (words_left == '0) ? F_WRDI : F_POLL;
          endcase
        end else div <= div + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aai_word_writer_chk.sv
module aai_word_writer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] byte_count,
  input logic             in_ready,
  input logic             busy,
  input logic             done,
  input logic             spi_sclk,
  input logic             spi_cs_n,
  input logic             spi_mosi
);
  p_sclk_low_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && !spi_cs_n && $past(spi_sclk)) |-> $stable(spi_mosi));
  p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_while_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_ready_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !spi_cs_n);
  p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count == '0) |=> done);
endmodule

bind aai_word_writer aai_word_writer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
  .in_ready(in_ready), .busy(busy), .done(done),
  .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
);

// File: tb/aai_word_writer_tb.sv
module aai_word_writer_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, start, in_valid, in_ready, busy, done;
  logic [23:0] start_addr;
  logic [15:0] byte_count;
  logic [7:0]  in_data;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  aai_word_writer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .busy(busy), .done(done), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flash slave model
  logic [7:0] cap_b[$];
  int         cap_l[$];
  int         cur_len = 0, bitc = 0, busy_rem = 0, busy_k = 0;
  logic [7:0] sh = 8'h00, first_b = 8'h00, miso_sh = 8'h00;
  bit         in_frame = 1'b0;
  assign spi_miso = miso_sh[7];

  always @(negedge spi_cs_n) begin in_frame = 1'b1; cur_len = 0; bitc = 0; end
  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 1'b0;
    cap_l.push_back(cur_len);
    if (first_b != 8'h05) busy_rem = busy_k;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      cap_b.push_back(sh);
      if (cur_len == 0) begin
        first_b = sh;
        if (sh == 8'h05) begin
          miso_sh = (busy_rem > 0) ? 8'h01 : 8'h00;
          if (busy_rem > 0) busy_rem--;
        end else miso_sh = 8'h00;
      end
      cur_len++;
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n && bitc != 0) miso_sh = {miso_sh[6:0], 1'b0};

  // byte stream source
  logic [7:0] src[$];
  int  consumed = 0;
  bit  stall_en = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (in_valid && in_ready) begin void'(src.pop_front()); consumed++; end
  end
  always @(negedge clk) begin
    in_valid = (src.size() > 0) && !(stall_en && (cyc % 7) < 3);
    in_data  = (src.size() > 0) ? src[0] : 8'h00;
  end

  // per-clock protocol reference
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) if (rst_n) begin
    chk(!(spi_cs_n && spi_sclk), "R8", "sclk high while deselected", spi_sclk, 0);
    if (spi_sclk && prev_sclk && !spi_cs_n)
      chk(spi_mosi == prev_mosi, "R8", "mosi moved while sclk high", spi_mosi, prev_mosi);
    if (in_ready) chk(!spi_cs_n, "R10", "in_ready outside frame", spi_cs_n, 0);
    if (done) done_cnt++;
    prev_sclk = spi_sclk;
    prev_mosi = spi_mosi;
  end

  // watchdog
  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [7:0] exp_b[$];
  int         exp_l[$];

  task automatic add_poll(input int k);
    for (int p = 0; p <= k; p++) begin exp_b.push_back(8'h05); exp_b.push_back(8'h00); exp_l.push_back(2); end
  endtask

  function automatic string tag_of(input logic [7:0] b0, input int len);
    if (b0 == 8'h05) return "R1/R3 poll";
    if (b0 == 8'h06) return "R1 write-enable";
    if (b0 == 8'h04) return "R5 write-disable";
    if (len == 6)    return "R2 first frame";
    return "R3 word frame";
  endfunction

  task automatic run_op(input logic [23:0] addr, input int n, input int k,
                        input bit stall, input bit poke);
    logic [7:0] d[$];
    int words, t, pos;
    exp_b.delete(); exp_l.delete(); src.delete(); cap_b.delete(); cap_l.delete();
    for (int i = 0; i < n; i++) begin d.push_back(8'((n * 17) + (i * 29) + 3)); src.push_back(d[i]); end
    words = (n + 1) / 2;
    add_poll(k);
    exp_b.push_back(8'h06); exp_l.push_back(1);
    for (int w = 0; w < words; w++) begin
      if (w > 0) add_poll(k);
      exp_b.push_back(8'hAD);
      if (w == 0) begin exp_b.push_back(addr[23:16]); exp_b.push_back(addr[15:8]); exp_b.push_back(addr[7:0]); end
      exp_b.push_back(d[2*w]);
      exp_b.push_back((2*w + 1 < n) ? d[2*w+1] : 8'hFF);
      exp_l.push_back(w == 0 ? 6 : 3);
    end
    exp_b.push_back(8'h04); exp_l.push_back(1);

    consumed = 0; busy_k = k; busy_rem = k; stall_en = stall; done_cnt = 0;
    start_addr = addr; byte_count = 16'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R6", "busy after start", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      byte_count = 16'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0; byte_count = 16'(n);
      chk(done == 1'b0, "R9", "start while busy caused done", done, 0);
    end
    t = 0;
    while (!done && t < 60000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R6", "done reached", done, 1);
    chk(spi_cs_n == 1'b1, "R5", "cs high at done", spi_cs_n, 1);
    chk(cap_l.size() == exp_l.size(), "R4", "frame count", cap_l.size(), exp_l.size());
    chk(consumed == n, "R4", "stream bytes taken", consumed, n);
    pos = 0;
    for (int f = 0; f < exp_l.size() && f < cap_l.size(); f++) begin
      bit ok;
      ok = (cap_l[f] == exp_l[f]);
      for (int b = 0; b < exp_l[f] && ok; b++)
        if (pos + b >= cap_b.size() || cap_b[pos + b] !== exp_b[pos + b]) ok = 1'b0;
      chk(ok, tag_of(exp_b[pos], exp_l[f]), "frame content", cap_l[f], exp_l[f]);
      if (!ok) break;
      pos += exp_l[f];
    end
    @(negedge clk);
    chk(done == 1'b0, "R6", "done lasted one cycle", done, 0);
    chk(busy == 1'b0, "R6", "busy low after done", busy, 0);
    chk(done_cnt == 1, poke ? "R9" : "R6", "done pulse count", done_cnt, 1);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0; byte_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R8", "reset cs_n", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R8", "reset sclk", spi_sclk, 0);
    chk(busy == 1'b0 && done == 1'b0, "R6", "reset busy/done", {busy, done}, 0);
    chk(in_ready == 1'b0, "R10", "reset in_ready", in_ready, 0);

    run_op(24'h123456, 4, 0, 1'b0, 1'b0);
    run_op(24'hA0B1C2, 5, 2, 1'b1, 1'b0);
    run_op(24'h00FF01, 1, 1, 1'b0, 1'b0);
    run_op(24'h7E0003, 2, 0, 1'b1, 1'b0);
    run_op(24'h3C5A96, 6, 1, 1'b0, 1'b1);

    cap_l.delete(); done_cnt = 0;
    byte_count = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R7", "zero count done next cycle", done, 1);
    chk(spi_cs_n == 1'b1 && in_ready == 1'b0, "R7", "zero count quiet", {spi_cs_n, in_ready}, 2);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", "zero count back to idle", {done, busy}, 0);
    chk(cap_l.size() == 0, "R7", "zero count frames", cap_l.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule